// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends a stream of stereo audio sample pairs over a three-wire serial audio link in I2S format. Each channel occupies a fixed slot of `SLOT_W` bit clocks. A left and right sample of `SAMPLE_W` bits (`SAMPLE_W <= SLOT_W`) is sent in two's complement, most significant bit first. The slot positions after the sample's last bit are driven low. The block is always the link master. It derives the serial bit clock from the system clock by an even, run-time selectable ratio and drives the channel-select line itself.

Sample pairs arrive through a valid/ready handshake into a one-pair holding buffer. At every frame boundary the buffered pair becomes the pair being sent, which frees the buffer for the next one. If the buffer is empty at a frame boundary, the previous pair is sent again and an underrun indication is raised for that frame. While `enable` is low, all three serial lines stay low. A frame starts with the left word as soon as the block is enabled.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset, and whenever `enable` is low, `sck`, `ws`, `sd` and `underrun` are all low.
- R2: While enabled, `sck` has a period of `2*H` system clocks with `H` clocks high and `H` clocks low, where `H = divHalf`, and a `divHalf` of 0 acts as 1.
- R3: While enabled, `ws` and `sd` change only in the system clock cycle in which `sck` goes from 1 to 0, so a receiver can latch them on the rising edge.
- R4: `ws` is low while the left word is being sent and high while the right word is being sent. Each channel lasts exactly `SLOT_W` bit clocks, and left and right words alternate.
- R5: Each word is sent MSB first. Its MSB is on `sd` at the first `sck` rising edge after the rising edge at which `ws` was first seen with its new value, which is one bit clock after the change.
- R6: The `SLOT_W - SAMPLE_W` slot positions after the sample's LSB are sent as 0.
- R7: `sampleReady` is high exactly when the holding buffer is empty. A pair is taken when `sampleValid` and `sampleReady` are both high, and the buffer is emptied only at a frame boundary.
- R8: If the buffer is empty at a frame boundary, the previous pair is sent again and `underrun` is high for that frame. `underrun` returns low at the first frame that starts with a fresh pair.
- R9: The first falling `sck` edge after `enable` rises puts the MSB of the left word of the buffered pair on `sd`, with `ws` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the serial link when high; idles all lines when low |
| divHalf | input | DIV_W | Half period of `sck` in system clocks (0 treated as 1) |
| sampleValid | input | 1 | A sample pair is offered |
| sampleReady | output | 1 | Holding buffer is empty and can take a pair |
| sampleLeft | input | SAMPLE_W | Left sample, two's complement |
| sampleRight | input | SAMPLE_W | Right sample, two's complement |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select: 0 left, 1 right |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The embedded assertions check the following on every cycle: `ws` and `sd` move only on a falling `sck` edge, the idle lines follow `enable` low, the buffer closes after each accepted pair, and `underrun` changes only at a frame boundary. The bench acts as a rising-edge receiver, which is the only way to show several properties. These are the bit-exact content and MSB alignment of each word, the zero fill after the LSB, the `sck` period for each divider setting, the strict left/right alternation, the start of the first frame, and the repeat of the last pair under underrun. The sweep sends every possible left sample value, and a permutation of all right sample values, at four divider settings.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Strobes passed from the timing control to the datapath, all valid for one system clock.
  typedef struct packed {
    logic clear;      // link disabled: force the lines idle
    logic fall;       // sck falls in this cycle
    logic frameStart; // this fall begins a new frame (left MSB)
    logic slotStart;  // this fall begins a channel slot
    logic rightSlot;  // the slot that this fall begins, or continues, is the right channel
  } sstStrobe_t;

endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divHalf,
  output logic             sck,
  output logic             ws,
  output sstStrobe_t       stb
);

  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] FRAME_LAST  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LEFT_LAST   = POS_W'(SLOT_W - 1);
  localparam logic [POS_W-1:0] RIGHT_FIRST = POS_W'(SLOT_W);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLim;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posNext;
  logic             sckReg;
  logic             wsReg;
  logic             toggle;
  logic             fallNow;
  logic             wsNext;

  always_comb begin
    halfLim = (divHalf == '0) ? DIV_W'(1) : divHalf;
    toggle  = enable && (divCnt >= halfLim - DIV_W'(1));
    fallNow = toggle && sckReg;
    posNext = (pos == FRAME_LAST) ? '0 : pos + POS_W'(1);
    // ws leads the data by one bit: it shows the channel of the next bit position
    wsNext  = (posNext >= LEFT_LAST) && (posNext != FRAME_LAST);
  end

  always_comb begin
    stb.clear      = !enable;
    stb.fall       = fallNow;
    stb.frameStart = fallNow && (posNext == '0);
    stb.slotStart  = fallNow && ((posNext == '0) || (posNext == RIGHT_FIRST));
    stb.rightSlot  = (posNext >= RIGHT_FIRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sckReg <= 1'b0;
      wsReg  <= 1'b0;
      pos    <= FRAME_LAST;
    end else if (!enable) begin
      divCnt <= '0;
      sckReg <= 1'b0;
      wsReg  <= 1'b0;
      pos    <= FRAME_LAST;
    end else begin
      if (toggle) begin
        divCnt <= '0;
        sckReg <= ~sckReg;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (fallNow) begin
        pos   <= posNext;
        wsReg <= wsNext;
      end
    end
  end

  assign sck = sckReg;
  assign ws  = wsReg;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sckReg && !wsReg)); // R1

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (wsReg != $past(wsReg)) |-> (($past(sckReg) && !sckReg) || !$past(enable))); // R3

endmodule

// File: rtl/sst_datapath.sv
module sst_datapath
  import sst_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  sstStrobe_t          stb,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                sd,
  output logic                underrun
);

  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] bufL, bufR, curL, curR;
  logic                bufFull;
  logic [SLOT_W-1:0]   shiftReg;
  logic [SLOT_W-1:0]   loadWord;
  logic [SAMPLE_W-1:0] selSample;
  logic                underrunReg;
  logic                accept;

  always_comb begin
    accept = sampleValid && !bufFull;
    if (stb.rightSlot) selSample = curR;
    else               selSample = bufFull ? bufL : curL;
  end

  // Zero fill of the unused low-order slot positions
  generate
    if (PAD_W == 0) begin : g_noPad
      assign loadWord = selSample;
    end else begin : g_pad
      assign loadWord = {selSample, {PAD_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufL        <= '0;
      bufR        <= '0;
      curL        <= '0;
      curR        <= '0;
      bufFull     <= 1'b0;
      shiftReg    <= '0;
      underrunReg <= 1'b0;
    end else begin
      if (stb.clear) begin
        shiftReg    <= '0;
        underrunReg <= 1'b0;
      end else if (stb.slotStart) begin
        shiftReg <= loadWord;
      end else if (stb.fall) begin
        shiftReg <= {shiftReg[SLOT_W-2:0], 1'b0};
      end
      if (stb.frameStart) begin
        if (bufFull) begin
          curL        <= bufL;
          curR        <= bufR;
          bufFull     <= 1'b0;
          underrunReg <= 1'b0;
        end else begin
          underrunReg <= 1'b1;
        end
      end
      if (accept) begin
        bufL    <= sampleLeft;
        bufR    <= sampleRight;
        bufFull <= 1'b1;
      end
    end
  end

  assign sampleReady = !bufFull;
  assign sd          = shiftReg[SLOT_W-1];
  assign underrun    = underrunReg;

  AST_BUF_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady); // R7

  AST_UNDERRUN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.frameStart && !stb.clear) |=> $stable(underrun)); // R8

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sd != $past(sd)) |-> $past(stb.fall || stb.clear)); // R3

endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sst_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [DIV_W-1:0]    divHalf,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                sck,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  sstStrobe_t stb;

  sst_ctrl #(
    .SLOT_W (SLOT_W),
    .DIV_W  (DIV_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .divHalf (divHalf),
    .sck     (sck),
    .ws      (ws),
    .stb     (stb)
  );

  sst_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W)
  ) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .sd          (sd),
    .underrun    (underrun)
  );

endmodule

// File: tb/stereo_serial_tx_tb_top.sv
module stereo_serial_tx_tb_top;

  localparam int SAMPLE_W = 5;
  localparam int SLOT_W   = 8;
  localparam int DIV_W    = 3;
  localparam int PAD_W    = SLOT_W - SAMPLE_W;
  localparam int NPAIRS   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [DIV_W-1:0] divHalf = '0;
  logic sampleValid = 1'b0;
  logic sampleReady;
  logic [SAMPLE_W-1:0] sampleLeft = '0;
  logic [SAMPLE_W-1:0] sampleRight = '0;
  logic sck, ws, sd, underrun;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stereo_serial_tx #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .DIV_W    (DIV_W)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .divHalf     (divHalf),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .sck         (sck),
    .ws          (ws),
    .sd          (sd),
    .underrun    (underrun)
  );

  function automatic logic [SAMPLE_W-1:0] pairL(int k);
    return SAMPLE_W'(k);
  endfunction

  function automatic logic [SAMPLE_W-1:0] pairR(int k);
    return SAMPLE_W'((k * 11 + 7) % (1 << SAMPLE_W));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Receiver model state
  bit monActive = 0;
  int effDiv = 1;
  int cycCnt = 0;
  int lastRise = 0;
  bit haveRise = 0;
  bit prevSck = 0, prevWs = 0, prevSd = 0;
  bit rxPrevWs = 1;
  bit startNext = 0;
  int rxCnt = SLOT_W;
  int rxCh = 0;
  int rxFrame = 0;
  int expectCh = 0;
  logic [SLOT_W-1:0] rxWord = '0;

  task automatic wordDone(input int ch, input logic [SLOT_W-1:0] word);
    int idx;
    logic [SLOT_W-1:0] expW;
    idx = (rxFrame < NPAIRS) ? rxFrame : NPAIRS - 1;
    check(ch == expectCh, "R4", "channel order", ch, expectCh);
    if (ch == 0) begin
      expW = SLOT_W'(pairL(idx)) << PAD_W;
      check(word == expW, "R5/R6/R9", "left word", int'(word), int'(expW));
      check(underrun == (rxFrame >= NPAIRS), "R8", "underrun flag",
            int'(underrun), int'(rxFrame >= NPAIRS));
    end else begin
      expW = SLOT_W'(pairR(idx)) << PAD_W;
      check(word == expW, "R5/R6", "right word", int'(word), int'(expW));
      rxFrame++;
    end
    expectCh = 1 - ch;
  endtask

  always @(negedge clk) begin
    cycCnt++;
    if (monActive) begin
      if ((ws != prevWs) || (sd != prevSd))
        check(prevSck && !sck, "R3", "ws/sd change off sck fall", int'(sck), 0);
      if (sck && !prevSck) begin
        if (haveRise)
          check(cycCnt - lastRise == 2 * effDiv, "R2", "sck period",
                cycCnt - lastRise, 2 * effDiv);
        haveRise = 1;
        lastRise = cycCnt;
        if (startNext) begin
          check(rxCnt == SLOT_W, "R4", "slot length", rxCnt, SLOT_W);
          rxCnt = 0;
          rxCh = int'(rxPrevWs);
          rxWord = '0;
        end
        if (rxCnt < SLOT_W) begin
          rxWord[SLOT_W-1-rxCnt] = sd;
          rxCnt++;
          if (rxCnt == SLOT_W) wordDone(rxCh, rxWord);
        end
        startNext = (ws != rxPrevWs);
        rxPrevWs = ws;
      end
    end
    prevSck = sck;
    prevWs = ws;
    prevSd = sd;
  end

  task automatic feed(input int k);
    while (!sampleReady) @(negedge clk);
    sampleValid = 1'b1;
    sampleLeft = pairL(k);
    sampleRight = pairR(k);
    @(negedge clk);
    sampleValid = 1'b0;
    check(!sampleReady, "R7", "ready after accept", int'(sampleReady), 0);
  endtask

  task automatic runPhase(input int d);
    divHalf = DIV_W'(d);
    effDiv = (d == 0) ? 1 : d;
    haveRise = 0;
    rxPrevWs = 1;
    startNext = 0;
    rxCnt = SLOT_W;
    rxFrame = 0;
    expectCh = 0;
    feed(0);
    repeat (20) @(negedge clk);
    check(!sck && !ws && !sd, "R1", "lines idle while disabled",
          int'({sck, ws, sd}), 0);
    check(!sampleReady, "R7", "buffer held while disabled", int'(sampleReady), 0);
    monActive = 1;
    enable = 1'b1;
    for (int k = 1; k < NPAIRS; k++) feed(k);
    while (rxFrame < NPAIRS + 2) @(negedge clk);
    monActive = 0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(!sck && !ws && !sd && !underrun, "R1", "idle after disable",
          int'({sck, ws, sd, underrun}), 0);
    check(sampleReady, "R7", "buffer empty after run", int'(sampleReady), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!sck && !ws && !sd && !underrun, "R1", "reset state",
          int'({sck, ws, sd, underrun}), 0);
    check(sampleReady, "R7", "ready after reset", int'(sampleReady), 1);
    for (int d = 0; d < 4; d++) runPhase(d);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1-timeout watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule